// File: doc/BRIEF.md
# Shared Square-Wave / Alarm-Interrupt Pin Controller

This block owns one shared output pin of a real-time clock. The pin carries one of two things. It can carry a square wave, divided from a 32.768 kHz tick enable. Or it can carry an active-low alarm interrupt. An 8-bit control register, written and read over a small register port, picks which one.

The block also keeps two sticky alarm flags, which a status register exposes. A flag is set by a strobe from the alarm comparators, and software clears it by writing zero to it. An input from power sensing says when the chip runs from its battery. On battery, the pin may be released to high impedance, and the oscillator-run indication can be switched off.

The pin is modelled as a level plus an output enable. The pad logic turns that pair into an open-drain driver.

Top module: `rtc_pin_ctrl`

## Requirements
- R1: After reset, the control register reads 0x1C, both alarm flags read 0, and osc_run is 1. The pin is then in interrupt mode with no interrupt pending, so pin_oe=1 and pin_lvl=1.
- R2: A write with reg_sel=0 loads all eight control bits. Reading with reg_sel=0 returns them. The bit layout, MSB first, is: halt-on-battery(7), battery-wave-enable(6), convert-request(5), rate(4:3), interrupt-mode(2), alarm-2 enable(1), alarm-1 enable(0).
- R3: The square wave is bit-accurate to a count of accepted ticks. It toggles every 16384, 16, 4 or 2 accepted ticks when rate is 00, 01, 10 or 11, giving 1 Hz, 1.024 kHz, 4.096 kHz and 8.192 kHz. It starts low after reset.
- R4: With interrupt-mode=0 on main power, pin_oe=1 and pin_lvl equals the square wave. Alarm flags never affect the pin.
- R5: With interrupt-mode=1, pin_oe=1. pin_lvl is 0 exactly when (alarm-1 flag and alarm-1 enable) or (alarm-2 flag and alarm-2 enable) holds.
- R6: A high alm1_hit or alm2_hit sets its flag at the next clock edge, whatever the mode and enable bits say. With reg_sel=1, flags read at bit 0 (alarm 1) and bit 1 (alarm 2). The other bits read 0.
- R7: A write with reg_sel=1 clears a flag whose data bit is 0 and leaves a flag whose data bit is 1 unchanged. A strobe in the same cycle as a clearing write wins, and the flag stays set.
- R8: On battery with interrupt-mode=0, the pin carries the square wave only if battery-wave-enable=1. Otherwise pin_oe=0 and pin_lvl reads 1.
- R9: osc_run is 0 exactly when halt-on-battery=1 and on_batt=1. While it is 0, ticks are ignored and the square wave holds its level.
- R10: An asserted interrupt stays asserted until the flag that caused it is cleared, or until its enable or the mode changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_32k | input | 1 | One-cycle enable at 32.768 kHz |
| on_batt | input | 1 | High while running from battery |
| alm1_hit | input | 1 | Alarm 1 match strobe |
| alm2_hit | input | 1 | Alarm 2 match strobe |
| reg_sel | input | 1 | 0 selects control, 1 selects status |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register |
| osc_run | output | 1 | Oscillator allowed to run |
| pin_oe | output | 1 | Pin actively driven |
| pin_lvl | output | 1 | Pin level when driven; 0 is an asserted interrupt |

## Verification
The divider is the one piece of hidden state. If it is off by even one tick, the pin edges shift from the expected positions. At 8.192 kHz that shows within two ticks. At 1 Hz it can take up to 16384 ticks to show. A corrupted flag or control bit is visible at once on reg_rdata. In interrupt mode it is also visible on the pin in the same cycle. The reference model tracks accepted ticks as a plain integer. It compares pin, read data and osc_run after every edge, so a miscount in any mode appears as soon as it affects a port.

// File: rtl/rtc_pin_ctrl.sv
module rtc_pin_ctrl #(
  parameter int DIV_W = 15
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_32k,
  input  logic       on_batt,
  input  logic       alm1_hit,
  input  logic       alm2_hit,
  input  logic       reg_sel,
  input  logic       reg_we,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       osc_run,
  output logic       pin_oe,
  output logic       pin_lvl
);
  localparam logic [7:0] CTRL_RST = 8'h1C;
  localparam int TAP_SLOW = DIV_W - 1;

  logic [7:0]       ctrl;
  logic [1:0]       flag;
  logic [DIV_W-1:0] div;
  logic             wave;
  logic             irq;

  wire halt_batt = ctrl[7];
  wire wave_batt = ctrl[6];
  wire irq_mode  = ctrl[2];

  assign osc_run = !(halt_batt && on_batt);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                  ctrl <= CTRL_RST;
    else if (reg_we && !reg_sel) ctrl <= reg_wdata;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) flag <= '0;
    else        flag <= ((reg_we && reg_sel) ? (flag & reg_wdata[1:0]) : flag)
                        | {alm2_hit, alm1_hit};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                  div <= '0;
    else if (tick_32k && osc_run) div <= div + 1'b1;

  always_comb
    case (ctrl[4:3])
      2'd0:    wave = div[TAP_SLOW];
      2'd1:    wave = div[4];
      2'd2:    wave = div[2];
      default: wave = div[1];
    endcase

  assign irq = |(flag & ctrl[1:0]);

  always_comb begin
    if (irq_mode) begin
      pin_oe  = 1'b1;
      pin_lvl = !irq;
    end else if (on_batt && !wave_batt) begin
      pin_oe  = 1'b0;
      pin_lvl = 1'b1;
    end else begin
      pin_oe  = 1'b1;
      pin_lvl = wave;
    end
  end

  assign reg_rdata = reg_sel ? {6'b0, flag} : ctrl;
endmodule

module rtc_pin_ctrl_chk #(
  parameter int DIV_W = 15
) (
  input logic             clk,
  input logic             rst_n,
  input logic             on_batt,
  input logic             alm1_hit,
  input logic             reg_sel,
  input logic             reg_we,
  input logic [7:0]       reg_wdata,
  input logic [7:0]       ctrl,
  input logic [1:0]       flag,
  input logic [DIV_W-1:0] div,
  input logic             osc_run,
  input logic             pin_oe,
  input logic             pin_lvl
);
  p_ctrl_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && !reg_sel) |=> (ctrl == $past(reg_wdata)));

  p_flag_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    alm1_hit |=> flag[0]);

  p_keep_on_one_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_sel && reg_wdata[0] && flag[0]) |=> flag[0]);

  p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (on_batt && !ctrl[2] && !ctrl[6]) |-> !pin_oe);

  p_div_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_run |=> $stable(div));

  p_irq_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[2] && !pin_lvl && !reg_we) |=> !pin_lvl);
endmodule

bind rtc_pin_ctrl rtc_pin_ctrl_chk #(.DIV_W(DIV_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .on_batt(on_batt), .alm1_hit(alm1_hit),
  .reg_sel(reg_sel), .reg_we(reg_we), .reg_wdata(reg_wdata),
  .ctrl(ctrl), .flag(flag), .div(div), .osc_run(osc_run),
  .pin_oe(pin_oe), .pin_lvl(pin_lvl)
);

// File: tb/tb_rtc_pin_ctrl.sv
module tb_rtc_pin_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic tick_32k = 1'b0, on_batt = 1'b0, alm1_hit = 1'b0, alm2_hit = 1'b0;
  logic reg_sel = 1'b0, reg_we = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic osc_run, pin_oe, pin_lvl;

  int total = 0, bad = 0;

  always #5 clk = ~clk;

  rtc_pin_ctrl dut (
    .clk(clk), .rst_n(rst_n), .tick_32k(tick_32k), .on_batt(on_batt),
    .alm1_hit(alm1_hit), .alm2_hit(alm2_hit), .reg_sel(reg_sel),
    .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .osc_run(osc_run), .pin_oe(pin_oe), .pin_lvl(pin_lvl)
  );

  // reference model
  logic [7:0] m_ctrl;
  logic [1:0] m_flag;
  int         m_ticks;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ctrl = 8'h1C; m_flag = 2'b00; m_ticks = 0;
    end else begin
      if (tick_32k && !(m_ctrl[7] && on_batt)) m_ticks = m_ticks + 1;
      if (reg_we && reg_sel) m_flag = m_flag & reg_wdata[1:0];
      m_flag = m_flag | {alm2_hit, alm1_hit};
      if (reg_we && !reg_sel) m_ctrl = reg_wdata;
    end
  end

  function automatic logic exp_wave();
    int half;
    case (m_ctrl[4:3])
      2'd0: half = 16384;
      2'd1: half = 16;
      2'd2: half = 4;
      default: half = 2;
    endcase
    return ((m_ticks / half) % 2) == 1;
  endfunction

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    logic e_oe, e_lvl;
    string tg;
    if (m_ctrl[2]) begin
      e_oe = 1'b1; e_lvl = !(|(m_flag & m_ctrl[1:0])); tg = "R5 pin";
    end else if (on_batt && !m_ctrl[6]) begin
      e_oe = 1'b0; e_lvl = 1'b1; tg = "R8 pin";
    end else begin
      e_oe = 1'b1; e_lvl = exp_wave(); tg = on_batt ? "R8 pin" : "R4 pin";
    end
    check({pin_oe, pin_lvl} == {e_oe, e_lvl}, tg, {pin_oe, pin_lvl}, {e_oe, e_lvl});
    check(osc_run == !(m_ctrl[7] && on_batt), "R9 osc_run", osc_run, !(m_ctrl[7] && on_batt));
    if (reg_sel) check(reg_rdata == {6'b0, m_flag}, "R7 status", reg_rdata, {6'b0, m_flag});
    else         check(reg_rdata == m_ctrl, "R2 ctrl", reg_rdata, m_ctrl);
  endtask

  task automatic step();
    @(negedge clk);
    compare_all();
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    reg_sel = sel; reg_wdata = d; reg_we = 1'b1;
    step();
    reg_we = 1'b0;
  endtask

  task automatic measure_half(input int expect_n, input string tag);
    logic prev;
    int n;
    tick_32k = 1'b1;
    prev = pin_lvl;
    for (int i = 0; i < 100 && pin_lvl == prev; i++) step();
    prev = pin_lvl; n = 0;
    for (int i = 0; i < 100 && pin_lvl == prev; i++) begin step(); n++; end
    check(n == expect_n, tag, n, expect_n);
  endtask

  initial begin
    #(1_500_000 * 1ns);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic held;
    repeat (3) step();
    rst_n = 1'b1;
    // R1 reset state
    step();
    check(reg_rdata == 8'h1C, "R1 ctrl reset", reg_rdata, 8'h1C);
    check(pin_oe && pin_lvl && osc_run, "R1 pin reset", {pin_oe, pin_lvl, osc_run}, 3'b111);
    reg_sel = 1'b1; step();
    check(reg_rdata == 8'h00, "R1 flags reset", reg_rdata, 8'h00);

    // R2 read-back
    wr(1'b0, 8'hA5); reg_sel = 1'b0; step();
    check(reg_rdata == 8'hA5, "R2 readback", reg_rdata, 8'hA5);
    wr(1'b0, 8'h5A); step();
    check(reg_rdata == 8'h5A, "R2 readback", reg_rdata, 8'h5A);

    // R3 / R4 square wave, alarms do not touch the pin
    wr(1'b0, 8'h10);
    measure_half(4, "R3 half 4.096k");
    wr(1'b0, 8'h08);
    measure_half(16, "R3 half 1.024k");
    wr(1'b0, 8'h18);
    measure_half(2, "R3 half 8.192k");
    wr(1'b0, 8'h03);
    tick_32k = 1'b1; alm1_hit = 1'b1; alm2_hit = 1'b1; step();
    alm1_hit = 1'b0; alm2_hit = 1'b0;
    reg_sel = 1'b1; step();
    check(reg_rdata[1:0] == 2'b11, "R6 flags set with mode 0", reg_rdata, 2'b11);
    for (int i = 0; i < 34000; i++) begin
      tick_32k = (i % 5) != 3;
      step();
    end
    tick_32k = 1'b0;

    // R5 / R10 interrupt
    wr(1'b1, 8'h00);
    wr(1'b0, 8'h05);
    step();
    check(pin_lvl == 1'b1, "R5 idle", pin_lvl, 1);
    alm1_hit = 1'b1; step(); alm1_hit = 1'b0;
    check(!pin_lvl && pin_oe, "R5 assert", pin_lvl, 0);
    held = 1'b1;
    for (int i = 0; i < 20; i++) begin step(); if (pin_lvl) held = 1'b0; end
    check(held, "R10 level held", held, 1);
    wr(1'b1, 8'hFE);
    check(pin_lvl == 1'b1, "R10 released on clear", pin_lvl, 1);
    alm2_hit = 1'b1; step(); alm2_hit = 1'b0;
    check(pin_lvl == 1'b1, "R5 masked alarm2", pin_lvl, 1);
    wr(1'b0, 8'h06);
    check(pin_lvl == 1'b0, "R5 alarm2 enabled", pin_lvl, 0);

    // R7 flag clearing
    alm1_hit = 1'b1; step(); alm1_hit = 1'b0;
    wr(1'b1, 8'hFF); reg_sel = 1'b1; step();
    check(reg_rdata[1:0] == 2'b11, "R7 write one keeps", reg_rdata, 2'b11);
    wr(1'b1, 8'h02); step();
    check(reg_rdata[1:0] == 2'b10, "R7 write zero clears", reg_rdata, 2'b10);
    alm2_hit = 1'b1; wr(1'b1, 8'h00); alm2_hit = 1'b0; step();
    check(reg_rdata[1:0] == 2'b10, "R7 set wins", reg_rdata, 2'b10);
    wr(1'b1, 8'h00);

    // R8 battery
    on_batt = 1'b1;
    wr(1'b0, 8'h18); step();
    check(pin_oe == 1'b0, "R8 released", pin_oe, 0);
    wr(1'b0, 8'h58);
    measure_half(2, "R8 wave on battery");
    wr(1'b0, 8'h5C); step();
    check(pin_oe && pin_lvl, "R8 irq mode on battery", {pin_oe, pin_lvl}, 2'b11);

    // R9 oscillator halt
    wr(1'b0, 8'hD8); step();
    check(osc_run == 1'b0, "R9 halted", osc_run, 0);
    held = pin_lvl; tick_32k = 1'b1;
    for (int i = 0; i < 50; i++) begin
      step();
      check(pin_lvl == held, "R9 wave frozen", pin_lvl, held);
    end
    on_batt = 1'b0; step();
    check(osc_run == 1'b1, "R9 runs on main", osc_run, 1);
    measure_half(2, "R9 resumed");

    // mixed traffic
    for (int i = 0; i < 4000; i++) begin
      tick_32k = $urandom % 2;
      on_batt  = ($urandom % 8) == 0;
      alm1_hit = ($urandom % 16) == 0;
      alm2_hit = ($urandom % 16) == 0;
      reg_sel  = $urandom % 2;
      reg_wdata = 8'($urandom);
      reg_we   = ($urandom % 10) == 0;
      step();
    end
    reg_we = 1'b0;
    step();

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule